// File: doc/BRIEF.md
# Backlight Control Register Slave

This block is a slave on a two-wire serial bus that holds the two settings of a display backlight controller. One is an 8-bit contrast level and the other is a brightness level. The slave answers to one fixed 7-bit address. It accepts Write Byte and Read Byte transactions, and each transaction selects one of the two settings through a command index. The register contents drive the downstream converters directly. Contrast is passed out at full width. Brightness is reduced to a 5-bit level code, and a larger code means a dimmer lamp.

The block runs on a fast system clock and oversamples the bus lines through synchronizers. SDA is open-drain: the block pulls it low by asserting `sdaLow` and otherwise leaves it released. Either bus condition, START or STOP, can arrive at any time and cancels whatever transfer is under way.

Top module: `bklt_smb_regs`

## Requirements
- R1: After reset `contrastCode` is 0x00, `brightCode` is 0, and `sdaLow` is 0 (SDA released).
- R2: The slave ACKs (pulls SDA low during the ninth clock) an address byte whose upper seven bits are 0101000. Any other address is NACKed, and the slave then ignores the rest of the transaction.
- R3: A Write Byte with command index 0xA9 stores the data byte as the contrast level, and `contrastCode` equals that byte (0xFF is the highest level, 0x00 the lowest).
- R4: A Write Byte with command index 0xAA stores the data byte as the brightness setting, and `brightCode` equals its bits [7:3]. Byte 0x00 gives code 0 (brightest) and 0xFF gives code 31 (dimmest).
- R5: A command index other than 0xA9 or 0xAA is NACKed. A data byte sent after it is not ACKed, and both outputs keep their values.
- R6: A Read Byte has three parts: a write-phase index, then a repeated START, then the address with R/W=1. The slave ACKs this and sends the selected register MSB first. It releases SDA after the master NACKs.
- R7: A START or STOP seen in the middle of a transaction ends it, and no register changes.
- R8: A register changes only after the data byte's ACK clock has ended. After the eighth data bit the outputs still hold their old values.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: A read-address byte is NACKed if no valid index was accepted since the last STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaLow | output | 1 | 1 pulls SDA low, 0 releases it |
| contrastCode | output | 8 | Contrast level to the contrast converter |
| brightCode | output | 5 | Brightness level code, larger is dimmer |

## Verification
The bench checks five corner cases, each against a specific failure:
- Data sent after a rejected index: a slave that forgot the rejection would ACK that byte or overwrite a setting.
- A transfer cut short by STOP after five data bits, or by a repeated START: a design that commits partial bytes would corrupt a register.
- The gap between the eighth data bit and the end of the ACK clock: an early-committing design would show the new value already there.
- Read-back through a repeated START: a read that is misaligned by one bit, or a slave that does not release SDA after the master's NACK, shows up in the received byte or in the line left low.
- A read address sent with no prior index, and a foreign address: an over-eager slave would ACK both.

// File: rtl/bklt_pkg.sv
package bklt_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DATA, ST_ACK, ST_RD, ST_RDACK, ST_WAIT
  } ctlState_t;

  typedef struct packed {
    logic              wrEn;
    logic              regSel;   // 0 contrast, 1 brightness
    logic [DATA_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/bklt_ctrl.sv
module bklt_ctrl
  import bklt_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR   = 7'b0101000,
  parameter logic [7:0] IDX_CONTRAST = 8'hA9,
  parameter logic [7:0] IDX_BRIGHT   = 8'hAA,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] rdData,
  output regStrobe_t        strb,
  output logic              sdaLow
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe, sdaPipe;
  logic sclS, sclD, sdaS, sdaD;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclS = sclPipe[PIPE_W-2];
  assign sclD = sclPipe[PIPE_W-1];
  assign sdaS = sdaPipe[PIPE_W-2];
  assign sdaD = sdaPipe[PIPE_W-1];

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  ctlState_t         state, afterAck;
  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              sdaLowR, haveIdx, regSelR, pendWrite, wrPulse, mAck;
  logic              addrHit, idxContrast, idxBright;

  assign addrHit     = (shReg[DATA_W-1:1] == SLAVE_ADDR);
  assign idxContrast = (shReg == IDX_CONTRAST);
  assign idxBright   = (shReg == IDX_BRIGHT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      afterAck  <= ST_IDLE;
      shReg     <= '0;
      bitCnt    <= '0;
      sdaLowR   <= 1'b0;
      haveIdx   <= 1'b0;
      regSelR   <= 1'b0;
      pendWrite <= 1'b0;
      wrPulse   <= 1'b0;
      mAck      <= 1'b0;
    end else begin
      wrPulse <= 1'b0;
      if (startDet) begin
        state     <= ST_ADDR;
        bitCnt    <= '0;
        sdaLowR   <= 1'b0;
        pendWrite <= 1'b0;
      end else if (stopDet) begin
        state     <= ST_IDLE;
        sdaLowR   <= 1'b0;
        haveIdx   <= 1'b0;
        pendWrite <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (sclRise && bitCnt < CNT_W'(DATA_W)) begin
              shReg  <= {shReg[DATA_W-2:0], sdaS};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == CNT_W'(DATA_W)) begin
              if (state == ST_ADDR) begin
                if (addrHit && (!shReg[0] || haveIdx)) begin
                  sdaLowR  <= 1'b1;
                  state    <= ST_ACK;
                  afterAck <= shReg[0] ? ST_RD : ST_CMD;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_CMD) begin
                if (idxContrast || idxBright) begin
                  sdaLowR  <= 1'b1;
                  state    <= ST_ACK;
                  afterAck <= ST_DATA;
                  regSelR  <= idxBright;
                  haveIdx  <= 1'b1;
                end else begin
                  haveIdx <= 1'b0;
                  state   <= ST_WAIT;
                end
              end else begin
                sdaLowR   <= 1'b1;
                state     <= ST_ACK;
                afterAck  <= ST_WAIT;
                pendWrite <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              state  <= afterAck;
              if (pendWrite) begin
                wrPulse   <= 1'b1;
                pendWrite <= 1'b0;
              end
              if (afterAck == ST_RD) begin
                shReg   <= rdData;
                sdaLowR <= ~rdData[DATA_W-1];
              end else begin
                sdaLowR <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (sclFall) begin
              if (bitCnt == CNT_W'(DATA_W - 1)) begin
                sdaLowR <= 1'b0;
                mAck    <= 1'b0;
                state   <= ST_RDACK;
              end else begin
                shReg   <= {shReg[DATA_W-2:0], 1'b0};
                sdaLowR <= ~shReg[DATA_W-2];
                bitCnt  <= bitCnt + 1'b1;
              end
            end
          end
          ST_RDACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                shReg   <= rdData;
                sdaLowR <= ~rdData[DATA_W-1];
                bitCnt  <= '0;
                state   <= ST_RD;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign strb   = '{wrEn: wrPulse, regSel: regSelR, wrData: shReg};
  assign sdaLow = sdaLowR;

  assert_start_abort_R7 : assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && !sdaLowR && !pendWrite));

  assert_stop_idle_R7 : assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaLowR && !wrPulse));

  assert_sda_quiet_high_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclD && !startDet && !stopDet) |=> $stable(sdaLowR));

  assert_single_strobe_R8 : assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  assert_read_needs_idx_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && afterAck == ST_RD) |-> haveIdx);
endmodule

// File: rtl/bklt_dp.sv
module bklt_dp
  import bklt_pkg::*;
#(
  parameter int BRT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] contrastCode,
  output logic [BRT_W-1:0]  brightCode
);
  logic [DATA_W-1:0] contrastReg, brightReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contrastReg <= '0;
      brightReg   <= '0;
    end else if (strb.wrEn) begin
      if (strb.regSel) brightReg   <= strb.wrData;
      else             contrastReg <= strb.wrData;
    end
  end

  assign rdData       = strb.regSel ? brightReg : contrastReg;
  assign contrastCode = contrastReg;
  assign brightCode   = brightReg[DATA_W-1 -: BRT_W];

  assert_regs_hold_R5 : assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> ($stable(contrastReg) && $stable(brightReg)));

  assert_one_reg_per_write_R3 : assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> ($stable(contrastReg) || $stable(brightReg)));
endmodule

// File: rtl/bklt_smb_regs.sv
module bklt_smb_regs
  import bklt_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR   = 7'b0101000,
  parameter logic [7:0] IDX_CONTRAST = 8'hA9,
  parameter logic [7:0] IDX_BRIGHT   = 8'hAA,
  parameter int         SYNC_STAGES  = 2,
  parameter int         BRT_W        = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaLow,
  output logic [DATA_W-1:0] contrastCode,
  output logic [BRT_W-1:0]  brightCode
);
  regStrobe_t        strb;
  logic [DATA_W-1:0] rdData;

  bklt_ctrl #(
    .SLAVE_ADDR(SLAVE_ADDR), .IDX_CONTRAST(IDX_CONTRAST),
    .IDX_BRIGHT(IDX_BRIGHT), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strb(strb), .sdaLow(sdaLow)
  );

  bklt_dp #(.BRT_W(BRT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData),
    .contrastCode(contrastCode), .brightCode(brightCode)
  );

  always_comb begin
    assert_reset_release_R1 : assert (rstN || !sdaLow);
  end
endmodule

// File: tb/sim_bklt_smb_regs.sv
module sim_bklt_smb_regs;
  localparam int Q  = 8;
  localparam int NV = 10;
  localparam logic [7:0] WADDR = 8'h50;
  localparam logic [7:0] RADDR = 8'h51;
  // {index, data, expected index ACK, expected contrast, expected brightness code}
  localparam logic [29:0] VEC [NV] = '{
    {8'hA9, 8'h3C, 1'b1, 8'h3C, 5'd0},
    {8'hAA, 8'hFF, 1'b1, 8'h3C, 5'd31},
    {8'hAA, 8'h00, 1'b1, 8'h3C, 5'd0},
    {8'hAA, 8'h57, 1'b1, 8'h3C, 5'd10},
    {8'hA9, 8'hFF, 1'b1, 8'hFF, 5'd10},
    {8'hAB, 8'h12, 1'b0, 8'hFF, 5'd10},
    {8'hA8, 8'h00, 1'b0, 8'hFF, 5'd10},
    {8'hA9, 8'h00, 1'b1, 8'h00, 5'd10},
    {8'hAA, 8'h88, 1'b1, 8'h00, 5'd17},
    {8'hA9, 8'h81, 1'b1, 8'h81, 5'd17}
  };

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic sdaLow, sdaBus;
  logic [7:0] contrastCode;
  logic [4:0] brightCode;
  int checks = 0, errors = 0, r9Viol = 0;
  logic done = 1'b0, prevScl = 1'b1, prevLow = 1'b0;

  always #2.5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaLow;

  bklt_smb_regs u0 (.clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaLow(sdaLow), .contrastCode(contrastCode), .brightCode(brightCode));

  always @(negedge clk) begin
    if (rstN && sclM && prevScl && sdaLow != prevLow) r9Viol++;
    prevScl = sclM;
    prevLow = sdaLow;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    end
  endtask

  task automatic ackSlot(output logic ack);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); ack = ~sdaBus; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    ackSlot(ack);
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclM = 1'b1; waitQ(); d[i] = sdaBus; waitQ(); sclM = 1'b0;
    end
    waitQ(); sdaM = ~mAck; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    sdaM = 1'b1;
  endtask

  task automatic readReg(input logic [7:0] idx, input logic [7:0] exp, input string req);
    logic a;
    logic [7:0] d;
    busStart(); sendByte(WADDR, a); sendByte(idx, a);
    busStart(); sendByte(RADDR, a);
    chk({req, " read address ACK"}, a, 1);
    recvByte(1'b0, d);
    chk({req, " read data"}, d, exp);
    chk("R6 SDA released after master NACK", sdaLow, 0);
    busStop();
  endtask

  initial begin
    logic a;
    repeat (4) @(negedge clk);
    chk("R1 contrast reset", contrastCode, 0);
    chk("R1 brightness reset", brightCode, 0);
    chk("R1 SDA released", sdaLow, 0);
    rstN = 1'b1;
    waitQ();

    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = (VEC[v][29:22] == 8'hA9) ? "R3" : (VEC[v][29:22] == 8'hAA) ? "R4" : "R5";
      busStart();
      sendByte(WADDR, a);
      chk("R2 own address ACK", a, 1);
      sendByte(VEC[v][29:22], a);
      chk({rq, " index ACK"}, a, VEC[v][13]);
      sendByte(VEC[v][21:14], a);
      chk({rq, " data ACK"}, a, VEC[v][13]);
      busStop();
      chk({rq, " contrast"}, contrastCode, VEC[v][12:5]);
      chk({rq, " brightness"}, brightCode, VEC[v][4:0]);
    end

    readReg(8'hA9, 8'h81, "R6 contrast");
    readReg(8'hAA, 8'h88, "R6 brightness");

    busStart(); sendByte(RADDR, a);
    chk("R10 read without index NACK", a, 0);
    busStop();

    busStart(); sendByte(8'h52, a);
    chk("R2 foreign address NACK", a, 0);
    sendByte(8'hA9, a);
    chk("R2 foreign index ignored", a, 0);
    sendByte(8'h11, a);
    busStop();
    chk("R2 contrast unchanged", contrastCode, 8'h81);

    busStart(); sendByte(WADDR, a); sendByte(8'hA9, a);
    sendBits(8'h22, 5);
    busStop();
    chk("R7 STOP mid data keeps contrast", contrastCode, 8'h81);

    busStart(); sendByte(WADDR, a); sendByte(8'hAA, a);
    sendBits(8'hF0, 6);
    busStart(); sendByte(WADDR, a); sendByte(8'hAA, a); sendByte(8'h10, a);
    busStop();
    chk("R7 write after repeated START abort", brightCode, 2);

    busStart(); sendByte(WADDR, a); sendByte(8'hA9, a);
    sendBits(8'h44, 8);
    waitQ();
    chk("R8 no update before ACK clock", contrastCode, 8'h81);
    ackSlot(a);
    chk("R8 data ACK", a, 1);
    chk("R8 update after ACK clock", contrastCode, 8'h44);
    busStop();

    chk("R9 SDA drive changes while SCL high", r9Viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule